// File: doc/BRIEF.md
# Management-Mode Entry/Exit Sequencer

This block sits next to a simple processor core and runs the hardware side of a system management interrupt. An active-low request is turned into a latched event. At the next instruction boundary reported by the core, the sequencer copies a fixed number of core state words into a reserved header region of a separate management memory. It then sends the core to a fixed handler entry address with interrupts masked and real addressing forced.

While the sequencer is in management mode, one active output marks every memory access as a management access, so a single address strobe serves both spaces. When the core reports the resume instruction, the header is read back word by word and handed to the core for reload. A flag bit in the first header word asks the core to restart an interrupted I/O instruction. A new request that arrives while the sequencer is already in management mode is latched. It is serviced after the exit, at the next instruction boundary.

Top module: `mgmt_seq`

## Requirements
- R1: A falling edge on `req_n` is recorded. Entry starts only in a cycle where `insn_done` is 1 and a request is recorded or is falling in that same cycle. The first save write appears in the next cycle. Without `insn_done`, no save write occurs and `mgmt_active` stays 0.
- R2: The save phase writes NW words in NW consecutive cycles. Word k goes to address HDR_BASE+k with `st_sel`=k, and `mem_wdata` carries the core's `st_word`.
- R3: In the cycle after the last save write, `redirect_en` is 1 for one cycle with `redirect_addr`=ENTRY_ADDR, and `arch_clr` pulses with it. `force_real` is 1 from that cycle until the cycle in which `rsm_exec` is seen, inclusive.
- R4: `mgmt_active`, `intr_block` and `nmi_block` are 1 from the first save write through the last restore read, and 0 otherwise. Every `mem_we` or `mem_re` cycle has `mgmt_active`=1.
- R5: `rsm_exec` seen in the handler phase starts the restore in the next cycle. NW reads go to HDR_BASE+k in consecutive cycles, and each read is forwarded to the core in the same cycle as `ld_en`=1, `ld_idx`=k, `ld_data`=`mem_rdata`. The words come from memory, not from the core.
- R6: In the cycle after the last restore read, `resume_go` is 1 for one cycle with `mgmt_active`=0. `io_restart` in that cycle equals bit IO_BIT (default 1) of header word 0 as read during the restore.
- R7: A falling edge of `req_n` during management mode is latched. It is not taken in the exit cycle, even if `insn_done` is 1 there. It is taken at the first `insn_done` after the exit.
- R8: `req_n` held low across a whole service, with no new falling edge, causes no second entry. `rsm_exec` outside the handler phase has no effect.
- R9: While `rst` is 1, and on the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Active-low management interrupt request |
| insn_done | input | 1 | Core reports an instruction boundary this cycle |
| rsm_exec | input | 1 | Core executes the resume instruction |
| st_word | input | DW | Core state word selected by `st_sel` |
| mem_rdata | input | DW | Management memory read data (same cycle) |
| mgmt_active | output | 1 | Management mode active, qualifies memory accesses |
| intr_block | output | 1 | Maskable interrupts disabled |
| nmi_block | output | 1 | Non-maskable interrupt disabled |
| force_real | output | 1 | Core forced to real addressing |
| arch_clr | output | 1 | Pulse: reset selected architected registers |
| redirect_en | output | 1 | Pulse: load `redirect_addr` into the program counter |
| redirect_addr | output | DW | Handler entry address |
| mem_we | output | 1 | Header write strobe |
| mem_re | output | 1 | Header read strobe |
| mem_addr | output | AW | Header word address |
| mem_wdata | output | DW | Header write data |
| st_sel | output | CW | Index of the state word to save |
| ld_en | output | 1 | Restore a state word into the core |
| ld_idx | output | CW | Index of the restored word |
| ld_data | output | DW | Restored word |
| resume_go | output | 1 | Pulse: core resumes in its saved mode |
| io_restart | output | 1 | With `resume_go`: restart the interrupted I/O instruction |

## Verification
Each result is due at a fixed cycle counted from a stimulus:
- the first save write one cycle after the boundary cycle;
- the redirect one cycle after the last write, which is boundary + NW + 1;
- the first read one cycle after `rsm_exec`;
- the resume pulse one cycle after the last read.

The bench drives inputs and samples outputs on the falling edge, and it walks these phases one cycle at a time, so every check lands on the exact cycle in which a result must appear and on no other. During the handler phase the bench alters one header word, so the restored data proves that the restore reads memory. Nested and held requests are probed around the exit cycle, where a premature entry would first show.

// File: rtl/mgmt_seq_pkg.sv
package mgmt_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SAVE,
        S_ENTER,
        S_HANDLER,
        S_RESTORE,
        S_EXIT
    } seq_state_e;

    typedef struct packed {
        logic active;
        logic wr;
        logic rd;
        logic entry;
        logic real_force;
        logic leave;
    } seq_ctl_t;

    function automatic seq_ctl_t decode_ctl(seq_state_e s);
        seq_ctl_t c;
        c.active     = (s == S_SAVE) || (s == S_ENTER) || (s == S_HANDLER) || (s == S_RESTORE);
        c.wr         = (s == S_SAVE);
        c.rd         = (s == S_RESTORE);
        c.entry      = (s == S_ENTER);
        c.real_force = (s == S_ENTER) || (s == S_HANDLER);
        c.leave      = (s == S_EXIT);
        return c;
    endfunction

endpackage

// File: rtl/mgmt_req_latch.sv
module mgmt_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic clear,
    output logic seen
);
    logic req_n_q;
    logic pend_q;
    logic fall;

    assign fall = req_n_q & ~req_n;
    assign seen = pend_q | fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_n_q <= 1'b1;
            pend_q  <= 1'b0;
        end else begin
            req_n_q <= req_n;
            if (clear)
                pend_q <= 1'b0;
            else if (fall)
                pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mgmt_hdr_ctr.sv
module mgmt_hdr_ctr #(
    parameter int NW = 16,
    parameter int AW = 16,
    parameter logic [AW-1:0] HDR_BASE = 16'hFE00,
    localparam int CW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] idx,
    output logic [AW-1:0] addr,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            idx <= '0;
        else if (step)
            idx <= idx + 1'b1;
    end

    assign last = (idx == CW'(NW - 1));
    assign addr = HDR_BASE + AW'(idx);
endmodule

// File: rtl/mgmt_seq_fsm.sv
module mgmt_seq_fsm
    import mgmt_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       rsm_exec,
    input  logic       last,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:    if (take) nxt = S_SAVE;
            S_SAVE:    if (last) nxt = S_ENTER;
            S_ENTER:   nxt = S_HANDLER;
            S_HANDLER: if (rsm_exec) nxt = S_RESTORE;
            S_RESTORE: if (last) nxt = S_EXIT;
            S_EXIT:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= S_IDLE;
        else
            state <= nxt;
    end
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
    import mgmt_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int NW = 16,
    parameter int AW = 16,
    parameter logic [AW-1:0] HDR_BASE = 16'hFE00,
    parameter logic [DW-1:0] ENTRY_ADDR = 32'h0003_8000,
    parameter int IO_BIT = 1,
    localparam int CW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_n,
    input  logic          insn_done,
    input  logic          rsm_exec,
    input  logic [DW-1:0] st_word,
    input  logic [DW-1:0] mem_rdata,
    output logic          mgmt_active,
    output logic          intr_block,
    output logic          nmi_block,
    output logic          force_real,
    output logic          arch_clr,
    output logic          redirect_en,
    output logic [DW-1:0] redirect_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [CW-1:0] st_sel,
    output logic          ld_en,
    output logic [CW-1:0] ld_idx,
    output logic [DW-1:0] ld_data,
    output logic          resume_go,
    output logic          io_restart
);
    seq_state_e    state;
    seq_ctl_t      ctl;
    logic          seen;
    logic          take;
    logic          last;
    logic [CW-1:0] idx;
    logic [AW-1:0] hdr_addr;
    logic          io_q;

    assign ctl  = decode_ctl(state);
    assign take = seen & insn_done & (state == S_IDLE);

    mgmt_req_latch u_req (
        .clk   (clk),
        .rst   (rst),
        .req_n (req_n),
        .clear (take),
        .seen  (seen)
    );

    mgmt_hdr_ctr #(
        .NW       (NW),
        .AW       (AW),
        .HDR_BASE (HDR_BASE)
    ) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (~(ctl.wr | ctl.rd)),
        .step (ctl.wr | ctl.rd),
        .idx  (idx),
        .addr (hdr_addr),
        .last (last)
    );

    mgmt_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .rsm_exec (rsm_exec),
        .last     (last),
        .state    (state)
    );

    // I/O restart flag comes from header word 0 as it is read back
    always_ff @(posedge clk) begin
        if (rst)
            io_q <= 1'b0;
        else if (ctl.rd && idx == '0)
            io_q <= mem_rdata[IO_BIT];
    end

    assign mgmt_active   = ctl.active;
    assign intr_block    = ctl.active;
    assign nmi_block     = ctl.active;
    assign force_real    = ctl.real_force;
    assign arch_clr      = ctl.entry;
    assign redirect_en   = ctl.entry;
    assign redirect_addr = ctl.entry ? ENTRY_ADDR : '0;
    assign mem_we        = ctl.wr;
    assign mem_re        = ctl.rd;
    assign mem_addr      = (ctl.wr | ctl.rd) ? hdr_addr : '0;
    assign mem_wdata     = ctl.wr ? st_word : '0;
    assign st_sel        = ctl.wr ? idx : '0;
    assign ld_en         = ctl.rd;
    assign ld_idx        = ctl.rd ? idx : '0;
    assign ld_data       = ctl.rd ? mem_rdata : '0;
    assign resume_go     = ctl.leave;
    assign io_restart    = ctl.leave & io_q;
endmodule

// File: rtl/mgmt_seq_chk.sv
module mgmt_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          insn_done,
    input logic          rsm_exec,
    input logic          mgmt_active,
    input logic          intr_block,
    input logic          nmi_block,
    input logic          force_real,
    input logic          redirect_en,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          resume_go
);
    AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(mgmt_active) |-> $past(insn_done)); // R1

    AST_SAVE_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R2

    AST_REDIRECT_AFTER_SAVE: assert property (@(posedge clk) disable iff (rst)
        redirect_en |-> ($past(mem_we) && !mem_we && force_real)); // R3

    AST_MASK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mgmt_active |-> (intr_block && nmi_block)); // R4

    AST_ACCESS_MARKED: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> mgmt_active); // R4

    AST_RESTORE_AFTER_RESUME: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_re) |-> $past(rsm_exec)); // R5

    AST_READ_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R5

    AST_RESUME_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        resume_go |-> ($past(mem_re) && !mgmt_active)); // R6

    AST_NO_ENTRY_AT_EXIT: assert property (@(posedge clk) disable iff (rst)
        resume_go |=> !mgmt_active); // R7
endmodule

bind mgmt_seq mgmt_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .insn_done   (insn_done),
    .rsm_exec    (rsm_exec),
    .mgmt_active (mgmt_active),
    .intr_block  (intr_block),
    .nmi_block   (nmi_block),
    .force_real  (force_real),
    .redirect_en (redirect_en),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_addr    (mem_addr),
    .resume_go   (resume_go)
);

// File: tb/mgmt_seq_tb.sv
module mgmt_seq_tb_top;
    localparam int DW = 32;
    localparam int NW = 16;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam logic [AW-1:0] BASE  = 16'hFE00;
    localparam logic [DW-1:0] ENTRY = 32'h0003_8000;
    localparam logic [DW-1:0] TAMPER = 32'h0000_FF00;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_n = 1'b1, insn_done = 1'b0, rsm_exec = 1'b0;
    logic [DW-1:0] st_word, mem_rdata;
    logic mgmt_active, intr_block, nmi_block, force_real, arch_clr, redirect_en;
    logic [DW-1:0] redirect_addr, mem_wdata, ld_data;
    logic mem_we, mem_re, ld_en, resume_go, io_restart;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] st_sel, ld_idx;

    logic [DW-1:0] hdr_mem [NW];
    logic [31:0] cur_seed = 32'h0;
    logic cur_io = 1'b0;
    int total = 0, bad = 0, cycles = 0;

    always #5 clk = ~clk;

    mgmt_seq dut_i (
        .clk(clk), .rst(rst), .req_n(req_n), .insn_done(insn_done), .rsm_exec(rsm_exec),
        .st_word(st_word), .mem_rdata(mem_rdata), .mgmt_active(mgmt_active),
        .intr_block(intr_block), .nmi_block(nmi_block), .force_real(force_real),
        .arch_clr(arch_clr), .redirect_en(redirect_en), .redirect_addr(redirect_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .st_sel(st_sel), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .resume_go(resume_go), .io_restart(io_restart)
    );

    function automatic logic [31:0] core_word(logic [31:0] seed, int k, logic io);
        logic [31:0] w;
        w = seed ^ (32'(k) * 32'h0103_0507);
        if (k == 0) w[1] = io;
        return w;
    endfunction

    assign st_word   = core_word(cur_seed, int'(st_sel), cur_io);
    assign mem_rdata = hdr_mem[mem_addr[CW-1:0]];

    always @(posedge clk) begin
        if (mem_we) hdr_mem[mem_addr[CW-1:0]] <= mem_wdata;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // request edge, then pre cycles without a boundary, then the boundary
    task automatic do_request(input int pre);
        req_n = 1'b0;
        for (int i = 0; i < pre; i++) begin
            @(negedge clk);
            check("R1 no entry before boundary", {31'b0, mgmt_active | mem_we}, 32'd0);
        end
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    task automatic do_save();
        for (int k = 0; k < NW; k++) begin
            check("R2 save strobe", {31'b0, mem_we}, 32'd1);
            check("R2 save addr", 32'(mem_addr), 32'(BASE) + 32'(k));
            check("R2 save data", mem_wdata, core_word(cur_seed, k, cur_io));
            check("R4 active+mask in save", {29'b0, mgmt_active, intr_block, nmi_block}, 32'd7);
            @(negedge clk);
        end
        check("R3 redirect pulse", {29'b0, redirect_en, arch_clr, force_real}, 32'd7);
        check("R3 redirect addr", redirect_addr, ENTRY);
        check("R3 no write at entry", {31'b0, mem_we}, 32'd0);
        for (int k = 0; k < NW; k++)
            check("R2 header content", hdr_mem[k], core_word(cur_seed, k, cur_io));
        @(negedge clk);
    endtask

    task automatic do_handler(input int hold, input bit nested);
        if (nested) req_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            check("R3 handler real, no redirect", {30'b0, force_real, redirect_en}, 32'd2);
            check("R4 active in handler", {31'b0, mgmt_active}, 32'd1);
            @(negedge clk);
        end
        hdr_mem[3] = hdr_mem[3] ^ TAMPER;
        rsm_exec = 1'b1;
        check("R3 real held at resume insn", {31'b0, force_real}, 32'd1);
        @(negedge clk);
        rsm_exec = 1'b0;
        if (nested) req_n = 1'b1;
    endtask

    task automatic do_restore(input bit exit_boundary);
        for (int k = 0; k < NW; k++) begin
            logic [31:0] e;
            e = core_word(cur_seed, k, cur_io);
            if (k == 3) e = e ^ TAMPER;
            check("R5 read strobe+load", {30'b0, mem_re, ld_en}, 32'd3);
            check("R5 read addr", 32'(mem_addr), 32'(BASE) + 32'(k));
            check("R5 load idx", 32'(ld_idx), 32'(k));
            check("R5 load data from memory", ld_data, e);
            check("R4 active in restore", {30'b0, mgmt_active, force_real}, 32'd2);
            @(negedge clk);
        end
        check("R6 resume pulse, inactive", {29'b0, resume_go, mgmt_active, intr_block}, 32'd4);
        check("R6 io restart flag", {31'b0, io_restart}, {31'b0, cur_io});
        if (exit_boundary) insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        check("R7 no entry in exit cycle", {30'b0, mgmt_active, resume_go}, 32'd0);
    endtask

    localparam logic [40:0] VECS [4] = '{
        {32'hA5A5_0000, 4'd0, 4'd0, 1'b0},
        {32'h1234_5678, 4'd3, 4'd2, 1'b1},
        {32'hFFFF_0F0F, 4'd1, 4'd5, 1'b0},
        {32'h0BAD_F00D, 4'd6, 4'd1, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset outputs", {24'b0, mgmt_active, mem_we, mem_re, redirect_en, resume_go,
              intr_block, force_real, arch_clr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 after reset", {28'b0, mgmt_active, mem_we, ld_en, io_restart}, 32'd0);

        foreach (VECS[v]) begin
            cur_seed = VECS[v][40:9];
            cur_io   = VECS[v][0];
            do_request(int'(VECS[v][8:5]));
            req_n = 1'b1;
            do_save();
            do_handler(int'(VECS[v][4:1]), 1'b0);
            do_restore(1'b0);
            repeat (2) @(negedge clk);
        end

        // R8: resume instruction outside the handler
        rsm_exec = 1'b1;
        @(negedge clk);
        rsm_exec = 1'b0;
        check("R8 stray resume ignored", {29'b0, mem_re, mgmt_active, resume_go}, 32'd0);
        @(negedge clk);
        check("R8 stray resume ignored later", {30'b0, mem_re, mgmt_active}, 32'd0);

        // R7: nested request latched and serviced after exit
        cur_seed = 32'h5555_AAAA; cur_io = 1'b1;
        do_request(1);
        req_n = 1'b1;
        do_save();
        do_handler(2, 1'b1);
        do_restore(1'b1);
        for (int i = 0; i < 3; i++) begin
            check("R7 pending waits for boundary", {31'b0, mgmt_active}, 32'd0);
            @(negedge clk);
        end
        cur_seed = 32'h0F0F_3C3C; cur_io = 1'b0;
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        check("R7 nested entry taken", {31'b0, mem_we}, 32'd1);
        do_save();
        do_handler(1, 1'b0);
        do_restore(1'b0);

        // R8: request held low, no new edge, no second entry
        cur_seed = 32'h7777_1111; cur_io = 1'b1;
        do_request(0);
        do_save();
        do_handler(1, 1'b0);
        do_restore(1'b1);
        insn_done = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R8 held request no reentry", {30'b0, mgmt_active, mem_we}, 32'd0);
        end
        insn_done = 1'b0;
        req_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule